// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryptor

This block encrypts one 128-bit block under a 128-bit key and moves every value through an 8-bit path. The caller presents the plaintext and the key one byte each per cycle. The block then runs all ten AES-128 rounds on two internal 16-byte register files, one for the cipher state and one for the round key. Afterwards it presents the ciphertext one byte per cycle on an 8-bit output. It suits area-limited designs where a few hundred cycles per block is acceptable.

Each round works through the state one byte at a time. A single substitution box is shared in time between the state bytes and the key-schedule bytes. The row rotation is a one-cycle byte move inside the state register file. Column mixing goes through a small unit that takes one byte in and gives one byte out per cycle and keeps four bytes of its own. Round keys are derived in place, just before each key addition.

Top module: `aes_byte_top`

## Requirements
- R1: After reset, `busy`, `outValid` and `done` are low.
- R2: An operation begins in the cycle where `start` is high while the block is idle, meaning neither `busy` nor `outValid` is high. In that cycle and the following 15 cycles, byte i of the plaintext and byte i of the key are taken from `dataIn` and `keyIn`, i counting from 0. From the next cycle onward, `busy` is high.
- R3: The output block equals the AES-128 encryption of the loaded plaintext under the loaded key. This covers the initial key addition, nine full rounds and a final round without column mixing, with round constants 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R4: Byte i of a block is state row (i mod 4), column (i div 4), for inputs and output alike. The ciphertext appears on `dataOut` with `outValid` high for 16 consecutive cycles, byte 0 first.
- R5: `done` is high only in the cycle carrying output byte 15.
- R6: `start` is ignored while `busy` is high. Input bytes presented then do not alter the result, and `busy` stays high.
- R7: The number of cycles from an accepted `start` to the first output byte is the same for every operation.
- R8: In the cycle after `done`, the block is idle and accepts a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when idle; byte 0 is presented with it |
| dataIn | input | 8 | Plaintext byte during loading |
| keyIn | input | 8 | Key byte during loading |
| busy | output | 1 | Loading or computing |
| outValid | output | 1 | `dataOut` carries a ciphertext byte |
| done | output | 1 | Final ciphertext byte is on `dataOut` |
| dataOut | output | 8 | Ciphertext byte |

## Verification
Embedded assertions check on every cycle that the controller never requests two datapath operations at once. They also check that an accepted start raises `busy`, that the output burst is unbroken until `done`, that `done` only comes with valid data and is followed by idle, and that the round constant stays in its legal sequence. Whether the ciphertext is correct, whether byte ordering matches, whether a start during computation is truly ignored and whether latency is constant can only be shown by the bench's scenarios. These use three known-answer vectors, back-to-back operations and a start injected mid-run.

// File: rtl/aes_byte_pkg.sv
package aes_byte_pkg;
  localparam int NBYTES = 16;
  localparam int BW     = 8;
  localparam int IDXW   = $clog2(NBYTES);
  localparam int ROUNDS = 10;
  localparam int RNDW   = $clog2(ROUNDS + 1);
  localparam int CNTW   = IDXW + 1;

  typedef struct packed {
    logic            load;
    logic            ark;
    logic            sub;
    logic            shr;
    logic            mcLoad;
    logic            mcEmit;
    logic            kSub;
    logic            kXor;
    logic            rconInit;
    logic            rconStep;
    logic [IDXW-1:0] idx;
  } aesStrobe_t;

  function automatic logic [BW-1:0] xtime(input logic [BW-1:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [BW-1:0] gmul(input logic [BW-1:0] a, input logic [BW-1:0] b);
    logic [BW-1:0] p, x, y;
    p = '0; x = a; y = b;
    for (int i = 0; i < BW; i++) begin
      if (y[0]) p = p ^ x;
      x = xtime(x);
      y = {1'b0, y[7:1]};
    end
    return p;
  endfunction

  function automatic logic [BW-1:0] rotl(input logic [BW-1:0] a, input int n);
    return (a << n) | (a >> (BW - n));
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [BW-1:0] sbox(input logic [BW-1:0] x);
    logic [BW-1:0] e, inv;
    e = x;
    for (int i = 0; i < 6; i++) e = gmul(gmul(e, e), x);
    inv = gmul(e, e);
    return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_mix_unit.sv
module aes_mix_unit
  import aes_byte_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          emit,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout
);
  logic [BW-1:0] colReg [4];

  // row formula for the byte at the head; rotation walks the rows
  assign dout = xtime(colReg[0]) ^ xtime(colReg[1]) ^ colReg[1] ^ colReg[2] ^ colReg[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) colReg[i] <= '0;
    end else if (load || emit) begin
      colReg[0] <= colReg[1];
      colReg[1] <= colReg[2];
      colReg[2] <= colReg[3];
      colReg[3] <= load ? din : colReg[0];
    end
  end

  a_r3_mix_exclusive: assert property (@(posedge clk) disable iff (!rstN) !(load && emit));
endmodule

// File: rtl/aes_byte_datapath.sv
module aes_byte_datapath
  import aes_byte_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  aesStrobe_t    strb,
  input  logic [BW-1:0] dataIn,
  input  logic [BW-1:0] keyIn,
  output logic [BW-1:0] dataOut
);
  logic [BW-1:0] stBank [NBYTES];
  logic [BW-1:0] keyBank [NBYTES];
  logic [BW-1:0] subWord [4];
  logic [BW-1:0] rcon;
  logic [BW-1:0] sboxIn, sboxOut, mixOut, stByte, keyByte, prevWord;
  logic [1:0]    lastColRow;

  assign stByte     = stBank[strb.idx];
  assign keyByte    = keyBank[strb.idx];
  assign lastColRow = strb.idx[1:0] + 2'd1;
  // shared S-box: key bytes 13,14,15,12 during kSub, else state byte
  assign sboxIn     = strb.kSub ? keyBank[{2'b11, lastColRow}] : stByte;
  assign sboxOut    = sbox(sboxIn);
  assign prevWord   = (strb.idx < IDXW'(4)) ? subWord[strb.idx[1:0]]
                                            : keyBank[strb.idx - IDXW'(4)];
  assign dataOut    = stByte;

  aes_mix_unit u_mix (
    .clk  (clk),
    .rstN (rstN),
    .load (strb.mcLoad),
    .emit (strb.mcEmit),
    .din  (stByte),
    .dout (mixOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NBYTES; i++) begin
        stBank[i]  <= '0;
        keyBank[i] <= '0;
      end
      for (int i = 0; i < 4; i++) subWord[i] <= '0;
      rcon <= 8'h01;
    end else begin
      if (strb.load) begin
        stBank[strb.idx]  <= dataIn;
        keyBank[strb.idx] <= keyIn;
      end
      if (strb.ark)    stBank[strb.idx] <= stByte ^ keyByte;
      if (strb.sub)    stBank[strb.idx] <= sboxOut;
      if (strb.mcEmit) stBank[strb.idx] <= mixOut;
      if (strb.shr) begin
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < 4; r++)
            stBank[4*c + r] <= stBank[4*((c + r) % 4) + r];
      end
      if (strb.kSub)
        subWord[strb.idx[1:0]] <= sboxOut ^ ((strb.idx[1:0] == 2'd0) ? rcon : 8'h00);
      if (strb.kXor)   keyBank[strb.idx] <= keyByte ^ prevWord;
      if (strb.rconInit)      rcon <= 8'h01;
      else if (strb.rconStep) rcon <= xtime(rcon);
    end
  end

  a_r3_one_operation: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.ark, strb.sub, strb.shr, strb.mcLoad, strb.mcEmit, strb.kSub, strb.kXor}));
  a_r3_rcon_legal: assert property (@(posedge clk) disable iff (!rstN)
    rcon inside {8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36, 8'h6c});
endmodule

// File: rtl/aes_byte_ctrl.sv
module aes_byte_ctrl
  import aes_byte_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output aesStrobe_t strb,
  output logic       busy,
  output logic       outValid,
  output logic       done
);
  typedef enum logic [3:0] {
    PH_IDLE, PH_LOAD, PH_ARK, PH_SUB, PH_SHR, PH_MIX, PH_KSUB, PH_KXOR, PH_OUT
  } phase_t;

  localparam logic [CNTW-1:0] LAST_BYTE = CNTW'(NBYTES - 1);
  localparam logic [CNTW-1:0] LAST_MIX  = CNTW'(2*NBYTES - 1);
  localparam logic [CNTW-1:0] LAST_KSUB = CNTW'(3);

  phase_t          phase;
  logic [CNTW-1:0] cnt;
  logic [RNDW-1:0] round;

  assign busy     = (phase != PH_IDLE) && (phase != PH_OUT);
  assign outValid = (phase == PH_OUT);
  assign done     = outValid && (cnt == LAST_BYTE);

  always_comb begin
    strb     = '0;
    strb.idx = cnt[IDXW-1:0];
    unique case (phase)
      PH_IDLE: begin
        strb.load     = start;
        strb.rconInit = start;
        strb.idx      = '0;
      end
      PH_LOAD: strb.load = 1'b1;
      PH_ARK:  strb.ark  = 1'b1;
      PH_SUB:  strb.sub  = 1'b1;
      PH_SHR:  strb.shr  = 1'b1;
      PH_MIX: begin
        strb.mcLoad = ~cnt[2];
        strb.mcEmit = cnt[2];
        strb.idx    = {cnt[4:3], cnt[1:0]};
      end
      PH_KSUB: begin
        strb.kSub = 1'b1;
        strb.idx  = {2'b00, cnt[1:0]};
      end
      PH_KXOR: begin
        strb.kXor     = 1'b1;
        strb.rconStep = (cnt == LAST_BYTE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      round <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) begin
            phase <= PH_LOAD;
            cnt   <= CNTW'(1);
            round <= '0;
          end
        end
        PH_LOAD: if (cnt == LAST_BYTE) begin phase <= PH_ARK; cnt <= '0; end
        PH_ARK: if (cnt == LAST_BYTE) begin
          cnt <= '0;
          if (round == RNDW'(ROUNDS)) phase <= PH_OUT;
          else begin
            phase <= PH_SUB;
            round <= round + 1'b1;
          end
        end
        PH_SUB: if (cnt == LAST_BYTE) begin phase <= PH_SHR; cnt <= '0; end
        PH_SHR: begin
          cnt   <= '0;
          phase <= (round == RNDW'(ROUNDS)) ? PH_KSUB : PH_MIX;
        end
        PH_MIX:  if (cnt == LAST_MIX)  begin phase <= PH_KSUB; cnt <= '0; end
        PH_KSUB: if (cnt == LAST_KSUB) begin phase <= PH_KXOR; cnt <= '0; end
        PH_KXOR: if (cnt == LAST_BYTE) begin phase <= PH_ARK;  cnt <= '0; end
        PH_OUT:  if (cnt == LAST_BYTE) begin phase <= PH_IDLE; cnt <= '0; end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !outValid) |=> busy);
  a_r4_burst_unbroken: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !done) |=> outValid);
  a_r5_done_with_data: assert property (@(posedge clk) disable iff (!rstN)
    done |-> outValid);
  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!outValid && !busy));
endmodule

// File: rtl/aes_byte_top.sv
module aes_byte_top
  import aes_byte_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] dataIn,
  input  logic [7:0] keyIn,
  output logic       busy,
  output logic       outValid,
  output logic       done,
  output logic [7:0] dataOut
);
  aesStrobe_t strb;

  aes_byte_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .strb     (strb),
    .busy     (busy),
    .outValid (outValid),
    .done     (done)
  );

  aes_byte_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dataIn  (dataIn),
    .keyIn   (keyIn),
    .dataOut (dataOut)
  );
endmodule

// File: tb/sim_aes_byte_top.sv
`timescale 1ns/1ps
module sim_aes_byte_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] keyIn = '0;
  logic       busy, outValid, done;
  logic [7:0] dataOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  int  lat = 0;
  int  firstLat = -1;
  bit  counting = 0;
  bit  awaitBusy = 0;
  int  pos = 0;

  always #2.5 clk = ~clk;

  aes_byte_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn), .keyIn(keyIn),
    .busy(busy), .outValid(outValid), .done(done), .dataOut(dataOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: pushes the expected bytes, then feeds the operands
  task automatic runOp(input logic [127:0] key, input logic [127:0] pt,
                       input logic [127:0] ct, input bit poke);
    for (int i = 0; i < 16; i++) expQ.push_back(ct[127-8*i -: 8]);
    @(negedge clk);
    while (busy || outValid) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      start  = (i == 0);
      dataIn = pt[127-8*i -: 8];
      keyIn  = key[127-8*i -: 8];
    end
    @(negedge clk);
    start = 1'b0; dataIn = '0; keyIn = '0;
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1; dataIn = 8'hff; keyIn = 8'hff;   // R6: must be ignored
      @(negedge clk);
      start = 1'b0; dataIn = '0; keyIn = '0;
      #1 check(busy == 1'b1, "R6 busy kept", busy, 1);
    end
  endtask

  // monitor: pops expected bytes as the design presents them
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (awaitBusy) begin
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        awaitBusy = 0;
      end
      if (counting) lat++;
      if (start && !busy && !outValid) begin
        counting = 1; lat = 0; awaitBusy = 1;
      end
      if (outValid) begin
        if (pos == 0) begin
          counting = 0;
          if (firstLat < 0) firstLat = lat;
          else check(lat == firstLat, "R7 latency", lat, firstLat);
        end
        if (expQ.size() == 0) check(0, "R4 unexpected byte", dataOut, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(dataOut == e, "R3 ciphertext byte", dataOut, e);
        end
        check(done == (pos == 15), "R5 done position", done, pos == 15);
        pos = (pos == 15) ? 0 : pos + 1;
      end else if (pos != 0) begin
        check(0, "R4 burst broken", pos, 16);
        pos = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(!busy && !outValid && !done, "R1 reset state", {busy, outValid, done}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1 check(!busy && !outValid && !done, "R1 idle after reset", {busy, outValid, done}, 0);
    // R3/R4 standard vector
    runOp(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0);
    // R8 back-to-back start right after done
    runOp(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
          128'h3925841d02dc09fbdc118597196a0b32, 1'b0);
    // R6 start poked mid-computation, all-zero operands
    runOp(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b1);
    @(negedge clk);
    while (busy || outValid || expQ.size() != 0) @(negedge clk);
    #1 check(!busy && !outValid && !done, "R8 idle at end", {busy, outValid, done}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule